// File: doc/BRIEF.md
# Rotating-Frame to Three-Phase Voltage Reference Transform

This block takes a voltage command given in a rotating two-axis frame with a zero-sequence term, and turns it into three stationary per-phase voltage references for a pulse-width modulator. The first stage rotates the direct and quadrature components back into a stationary two-axis pair, using the sine and cosine of the grid angle. An upstream angle tracker supplies these values. The zero-sequence term passes through this stage unchanged. The second stage projects the stationary pair onto three axes spaced 120 degrees apart, using fixed coefficients of one half and of the cosine of 30 degrees. It adds the zero-sequence term to every phase.

Every phase result is clamped to an upper and a lower bound before it leaves the block. Both bounds are inputs and can change while the block runs. All samples are signed Q1.15. Each input sample arrives with a strobe. The pipeline accepts one sample on every clock and returns each result three clocks later, with its own strobe.

Top module: `dqabc_xform`

## Requirements
- R1: Stage one forms alpha = round((d·cos − q·sin) / 2^15). Here round() means adding 2^14 and then shifting right arithmetically by 15. The result saturates to the range −32768..32767.
- R2: Stage one forms beta = round((d·sin + q·cos) / 2^15), with the same rounding and saturation as R1.
- R3: The zero-sequence input passes through stage one unchanged. When alpha and beta are both 0, all three phases equal the zero-sequence input.
- R4: Phase a before the clamp equals alpha + zero, saturated to 16 bits.
- R5: Phase b before the clamp equals round((−16384·alpha + 28378·beta + 32768·zero) / 2^15), saturated to 16 bits.
- R6: Phase c before the clamp equals round((−16384·alpha − 28378·beta + 32768·zero) / 2^15), saturated to 16 bits.
- R7: When lim_lo ≤ lim_hi, each phase output is limited to the range lim_lo..lim_hi. The bounds used are the values present on the clock edge two cycles after the input edge.
- R8: When lim_lo > lim_hi, all three phase outputs equal lim_lo.
- R9: out_valid rises exactly 3 clocks after each edge that samples in_valid high, for back-to-back input and for gapped input alike. It is low at all other times.
- R10: While rst is high and after rst is released, out_valid is 0 and all three phase outputs are 0 until the first result arrives.
- R11: Zero d, q and zero inputs give 0 on all phases. d = 32767, q = 0, zero = 0, sin = 0 and cos = 32767 give phases 32766, −16383 and −16383.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input sample strobe |
| d_in | input | 16 | Direct-axis component, Q1.15 |
| q_in | input | 16 | Quadrature-axis component, Q1.15 |
| z_in | input | 16 | Zero-sequence component, Q1.15 |
| sin_in | input | 16 | Sine of grid angle, Q1.15 |
| cos_in | input | 16 | Cosine of grid angle, Q1.15 |
| lim_hi | input | 16 | Upper output bound, signed |
| lim_lo | input | 16 | Lower output bound, signed |
| out_valid | output | 1 | Output sample strobe |
| ph_a | output | 16 | Phase a reference, Q1.15 |
| ph_b | output | 16 | Phase b reference, Q1.15 |
| ph_c | output | 16 | Phase c reference, Q1.15 |

## Verification
Four properties are checked on every cycle:
- the three-cycle strobe latency;
- the bounds that hold whenever the limits are ordered;
- the forcing of every phase to the lower limit when the limits are inverted;
- the flow of an all-zero rotating input, or of a pure zero-sequence input, through the stages.

The bench's scenarios are the only way to show the exact rounded values, the saturation at full-scale angles and the 28378 coefficient. They also show which clock's limits a result uses when the limits change in the middle of a stream.

// File: rtl/dqabc_pkg.sv
package dqabc_pkg;

    localparam int NPH = 3;

    // round half up then arithmetic shift right by f
    function automatic logic signed [63:0] rnd_shift(input logic signed [63:0] x, input int f);
        logic signed [63:0] half;
        half = 64'sd1 <<< (f - 1);
        return (x + half) >>> f;
    endfunction

    // saturate to a signed w-bit range, result still 64 bits wide
    function automatic logic signed [63:0] sat_to(input logic signed [63:0] x, input int w);
        logic signed [63:0] top;
        logic signed [63:0] bot;
        top = (64'sd1 <<< (w - 1)) - 64'sd1;
        bot = -(64'sd1 <<< (w - 1));
        if (x > top)
            return top;
        else if (x < bot)
            return bot;
        else
            return x;
    endfunction

endpackage

// File: rtl/dqabc_rotate.sv
module dqabc_rotate
    import dqabc_pkg::*;
#(
    parameter int W = 16,
    parameter int F = 15
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                v_i,
    input  logic signed [W-1:0] d_i,
    input  logic signed [W-1:0] q_i,
    input  logic signed [W-1:0] z_i,
    input  logic signed [W-1:0] sin_i,
    input  logic signed [W-1:0] cos_i,
    output logic                v_o,
    output logic signed [W-1:0] alpha_o,
    output logic signed [W-1:0] beta_o,
    output logic signed [W-1:0] zero_o
);

    logic signed [63:0] alpha_full;
    logic signed [63:0] beta_full;
    logic signed [W-1:0] alpha_n;
    logic signed [W-1:0] beta_n;

    always_comb begin
        alpha_full = 64'(d_i) * 64'(cos_i) - 64'(q_i) * 64'(sin_i);
        beta_full  = 64'(d_i) * 64'(sin_i) + 64'(q_i) * 64'(cos_i);
        alpha_n    = W'(sat_to(rnd_shift(alpha_full, F), W));
        beta_n     = W'(sat_to(rnd_shift(beta_full, F), W));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            v_o     <= 1'b0;
            alpha_o <= '0;
            beta_o  <= '0;
            zero_o  <= '0;
        end else begin
            v_o <= v_i;
            if (v_i) begin
                alpha_o <= alpha_n;
                beta_o  <= beta_n;
                zero_o  <= z_i;
            end
        end
    end

    // R11: a zero rotating input leaves a zero stationary pair
    a_r11_zero_rot: assert property (@(posedge clk) disable iff (rst)
        (v_i && d_i == '0 && q_i == '0) |=> (v_o && alpha_o == '0 && beta_o == '0));

endmodule

// File: rtl/dqabc_project.sv
module dqabc_project
    import dqabc_pkg::*;
#(
    parameter int W = 16,
    parameter int F = 15
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                v_i,
    input  logic signed [W-1:0] alpha_i,
    input  logic signed [W-1:0] beta_i,
    input  logic signed [W-1:0] zero_i,
    output logic                v_o,
    output logic signed [W-1:0] ph_o [NPH]
);

    localparam longint ONE  = 64'sd1 <<< F;
    localparam longint HALF = 64'sd1 <<< (F - 1);
    localparam longint KSIN = longint'(0.8660254037844386 * real'(ONE));

    logic signed [W-1:0] ph_n [NPH];

    for (genvar g = 0; g < NPH; g++) begin : g_phase
        localparam longint CA = (g == 0) ? ONE : -HALF;
        localparam longint CB = (g == 0) ? 64'sd0 : ((g == 1) ? KSIN : -KSIN);
        logic signed [63:0] acc;
        always_comb begin
            acc     = CA * 64'(alpha_i) + CB * 64'(beta_i) + ONE * 64'(zero_i);
            ph_n[g] = W'(sat_to(rnd_shift(acc, F), W));
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            v_o <= 1'b0;
            for (int k = 0; k < NPH; k++) ph_o[k] <= '0;
        end else begin
            v_o <= v_i;
            if (v_i) begin
                for (int k = 0; k < NPH; k++) ph_o[k] <= ph_n[k];
            end
        end
    end

    // R3: with no stationary pair, every phase carries the zero-sequence term
    a_r3_zero_only: assert property (@(posedge clk) disable iff (rst)
        (v_i && alpha_i == '0 && beta_i == '0) |=>
        (ph_o[0] == $past(zero_i) && ph_o[1] == $past(zero_i) && ph_o[2] == $past(zero_i)));

endmodule

// File: rtl/dqabc_clamp.sv
module dqabc_clamp
    import dqabc_pkg::*;
#(
    parameter int W = 16
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                v_i,
    input  logic signed [W-1:0] x_i [NPH],
    input  logic signed [W-1:0] lo_i,
    input  logic signed [W-1:0] hi_i,
    output logic                v_o,
    output logic signed [W-1:0] y_o [NPH]
);

    logic signed [W-1:0] y_n [NPH];

    for (genvar g = 0; g < NPH; g++) begin : g_lim
        always_comb begin
            if (lo_i > hi_i)
                y_n[g] = lo_i;
            else if (x_i[g] > hi_i)
                y_n[g] = hi_i;
            else if (x_i[g] < lo_i)
                y_n[g] = lo_i;
            else
                y_n[g] = x_i[g];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            v_o <= 1'b0;
            for (int k = 0; k < NPH; k++) y_o[k] <= '0;
        end else begin
            v_o <= v_i;
            if (v_i) begin
                for (int k = 0; k < NPH; k++) y_o[k] <= y_n[k];
            end
        end
    end

    // R7: ordered limits bound every phase
    a_r7_bounds: assert property (@(posedge clk) disable iff (rst)
        (v_i && lo_i <= hi_i) |=>
        (y_o[0] >= $past(lo_i) && y_o[0] <= $past(hi_i) &&
         y_o[1] >= $past(lo_i) && y_o[1] <= $past(hi_i) &&
         y_o[2] >= $past(lo_i) && y_o[2] <= $past(hi_i)));

    // R8: inverted limits force the lower bound
    a_r8_inverted: assert property (@(posedge clk) disable iff (rst)
        (v_i && lo_i > hi_i) |=>
        (y_o[0] == $past(lo_i) && y_o[1] == $past(lo_i) && y_o[2] == $past(lo_i)));

endmodule

// File: rtl/dqabc_xform.sv
module dqabc_xform
    import dqabc_pkg::*;
#(
    parameter int W = 16,
    parameter int F = 15
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                in_valid,
    input  logic signed [W-1:0] d_in,
    input  logic signed [W-1:0] q_in,
    input  logic signed [W-1:0] z_in,
    input  logic signed [W-1:0] sin_in,
    input  logic signed [W-1:0] cos_in,
    input  logic signed [W-1:0] lim_hi,
    input  logic signed [W-1:0] lim_lo,
    output logic                out_valid,
    output logic signed [W-1:0] ph_a,
    output logic signed [W-1:0] ph_b,
    output logic signed [W-1:0] ph_c
);

    logic                v_rot;
    logic signed [W-1:0] alpha;
    logic signed [W-1:0] beta;
    logic signed [W-1:0] zero;
    logic                v_prj;
    logic signed [W-1:0] ph_raw [NPH];
    logic signed [W-1:0] ph_lim [NPH];

    dqabc_rotate #(.W(W), .F(F)) u_rotate (
        .clk     (clk),
        .rst     (rst),
        .v_i     (in_valid),
        .d_i     (d_in),
        .q_i     (q_in),
        .z_i     (z_in),
        .sin_i   (sin_in),
        .cos_i   (cos_in),
        .v_o     (v_rot),
        .alpha_o (alpha),
        .beta_o  (beta),
        .zero_o  (zero)
    );

    dqabc_project #(.W(W), .F(F)) u_project (
        .clk     (clk),
        .rst     (rst),
        .v_i     (v_rot),
        .alpha_i (alpha),
        .beta_i  (beta),
        .zero_i  (zero),
        .v_o     (v_prj),
        .ph_o    (ph_raw)
    );

    dqabc_clamp #(.W(W)) u_clamp (
        .clk  (clk),
        .rst  (rst),
        .v_i  (v_prj),
        .x_i  (ph_raw),
        .lo_i (lim_lo),
        .hi_i (lim_hi),
        .v_o  (out_valid),
        .y_o  (ph_lim)
    );

    assign ph_a = ph_lim[0];
    assign ph_b = ph_lim[1];
    assign ph_c = ph_lim[2];

    // cycles since reset, saturating, so the latency check never looks before reset
    logic [1:0] age;
    always_ff @(posedge clk) begin
        if (rst)
            age <= 2'd0;
        else if (age != 2'd3)
            age <= age + 2'd1;
    end

    // R9: fixed three-cycle strobe latency
    a_r9_latency: assert property (@(posedge clk) disable iff (rst)
        (age == 2'd3) |-> (out_valid == $past(in_valid, 3)));

endmodule

// File: tb/dqabc_xform_tb_top.sv
`timescale 1ns/1ps
module dqabc_xform_tb_top;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic in_valid = 1'b0;
    logic signed [15:0] d_in = '0, q_in = '0, z_in = '0, sin_in = '0, cos_in = '0;
    logic signed [15:0] lim_hi = 16'sd32767, lim_lo = -16'sd32768;
    logic out_valid;
    logic signed [15:0] ph_a, ph_b, ph_c;

    always #2.5 clk = ~clk;

    dqabc_xform dut_i (
        .clk(clk), .rst(rst), .in_valid(in_valid),
        .d_in(d_in), .q_in(q_in), .z_in(z_in), .sin_in(sin_in), .cos_in(cos_in),
        .lim_hi(lim_hi), .lim_lo(lim_lo),
        .out_valid(out_valid), .ph_a(ph_a), .ph_b(ph_b), .ph_c(ph_c)
    );

    typedef struct {
        int     due;
        longint a;
        longint b;
        longint c;
        string  tag;
    } exp_t;

    exp_t   exp_q[$];
    int     lo_h[int];
    int     hi_h[int];
    int     cyc = 0;
    int     checks = 0;
    int     errors = 0;
    int     cur_hi = 32767;
    int     cur_lo = -32768;
    bit     done = 0;

    function automatic longint rs(input longint x);
        return (x + 64'sd16384) >>> 15;
    endfunction

    function automatic longint sat(input longint x);
        if (x > 32767) return 32767;
        if (x < -32768) return -32768;
        return x;
    endfunction

    function automatic longint clampf(input longint x, input longint lo, input longint hi);
        if (lo > hi) return lo;
        if (x > hi) return hi;
        if (x < lo) return lo;
        return x;
    endfunction

    task automatic chk(input string what, input longint act, input longint expv);
        checks++;
        if (act != expv) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", what, act, expv);
        end
    endtask

    task automatic check_out();
        bit ev;
        exp_t e;
        ev = (exp_q.size() > 0) && (exp_q[0].due == cyc);
        chk("R9 out_valid timing", longint'(out_valid), longint'(ev));
        if (ev) begin
            e = exp_q.pop_front();
            chk({e.tag, " R4 phase a"}, ph_a, clampf(e.a, lo_h[cyc-1], hi_h[cyc-1]));
            chk({e.tag, " R5 phase b"}, ph_b, clampf(e.b, lo_h[cyc-1], hi_h[cyc-1]));
            chk({e.tag, " R6 phase c"}, ph_c, clampf(e.c, lo_h[cyc-1], hi_h[cyc-1]));
        end
    endtask

    task automatic step(input bit v, input int d, input int q, input int z,
                        input int s, input int c, input string tag);
        exp_t   e;
        longint al, be;
        check_out();
        in_valid = v;
        d_in = 16'(d); q_in = 16'(q); z_in = 16'(z); sin_in = 16'(s); cos_in = 16'(c);
        lim_hi = 16'(cur_hi); lim_lo = 16'(cur_lo);
        hi_h[cyc] = cur_hi;
        lo_h[cyc] = cur_lo;
        if (v) begin
            al = sat(rs(longint'(d) * c - longint'(q) * s));
            be = sat(rs(longint'(d) * s + longint'(q) * c));
            e.due = cyc + 3;
            e.a = sat(al + z);
            e.b = sat(rs(-16384 * al + 28378 * be + 32768 * longint'(z)));
            e.c = sat(rs(-16384 * al - 28378 * be + 32768 * longint'(z)));
            e.tag = tag;
            exp_q.push_back(e);
        end
        cyc++;
        @(negedge clk);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0, 0, "idle");
    endtask

    function automatic int rnd16();
        return int'($urandom_range(65535)) - 32768;
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL R9 watchdog actual hung expected finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        chk("R10 out_valid in reset", out_valid, 0);
        chk("R10 ph_a in reset", ph_a, 0);
        rst = 1'b0;
        @(negedge clk);
        chk("R10 out_valid after reset", out_valid, 0);
        chk("R10 ph_b after reset", ph_b, 0);
        chk("R10 ph_c after reset", ph_c, 0);

        // R11 literal corner values
        step(1, 0, 0, 0, 12000, -9000, "R11");
        idle(2);
        chk("R11 zero phase a", ph_a, 0);
        chk("R11 zero phase b", ph_b, 0);
        chk("R11 zero phase c", ph_c, 0);
        step(1, 32767, 0, 0, 0, 32767, "R11");
        idle(2);
        chk("R11 unit phase a", ph_a, 32766);
        chk("R11 unit phase b", ph_b, -16383);
        chk("R11 unit phase c", ph_c, -16383);
        idle(2);

        // R1 / R2 angle sweeps, back to back
        for (int k = 0; k < 32; k++) begin
            real th;
            th = 3.14159265358979 * k / 16.0;
            step(1, 20000, 0, 0, int'(32767.0 * $sin(th)), int'(32767.0 * $cos(th)), "R1");
        end
        for (int k = 0; k < 32; k++) begin
            real th;
            th = 3.14159265358979 * k / 16.0;
            step(1, 0, 20000, 0, int'(32767.0 * $sin(th)), int'(32767.0 * $cos(th)), "R2");
        end
        // R3 zero-sequence only
        step(1, 0, 0, 1000, 5000, 30000, "R3");
        step(1, 0, 0, -5000, -32768, 0, "R3");
        step(1, 0, 0, 32767, 0, 32767, "R3");
        // R1 R2 saturation at full scale
        step(1, -32768, -32768, 0, -32768, -32768, "R1");
        step(1, 32767, -32768, 0, 32767, 32767, "R2");
        step(1, -32768, 32767, -32768, 23170, 23170, "R5");
        // mixed streaming
        for (int k = 0; k < 300; k++)
            step(1, rnd16() / 2, rnd16() / 2, rnd16() / 4, rnd16(), rnd16(), "R6");
        // R9 gapped input
        for (int k = 0; k < 60; k++)
            step(k % 3 == 0, rnd16(), rnd16(), rnd16() / 8, rnd16(), rnd16(), "R9");
        // R7 narrow limits, changed mid-stream
        cur_hi = 3000; cur_lo = -2000;
        for (int k = 0; k < 100; k++) begin
            if (k == 50) begin cur_hi = 500; cur_lo = -12000; end
            step(1, rnd16(), rnd16(), rnd16() / 4, rnd16(), rnd16(), "R7");
        end
        // R8 inverted limits
        cur_hi = -1000; cur_lo = 1000;
        for (int k = 0; k < 40; k++)
            step(1, rnd16(), rnd16(), rnd16(), rnd16(), rnd16(), "R8");
        cur_hi = 32767; cur_lo = -32768;
        idle(6);
        chk("R9 all results delivered", exp_q.size(), 0);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule